// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-signal serial link that lets a host controller set up and inspect a small bank of configuration registers. The host holds a frame strobe low for the length of one transfer, toggles a serial clock, and moves bits over one shared data line. Each transfer opens with a four-bit register address and one direction bit, then carries a data field whose length the host chooses freely, from a single bit up to the full width of the addressed register.

Writes may be partial. The bits that arrive fill the register from its most significant end, and the lower bits keep their old values. The update takes effect when the strobe returns high. Reads return the register MSB first. The block takes over the data line on the clock edge that follows the direction bit, and gives it back as soon as the host ends the frame, which the host may do at any point. Writing the dedicated reset address restores every register to its default. The strobe, clock and data inputs are asynchronous to the block clock, and the block oversamples them.

The register map is a package constant. Address 0 is the reset register and holds no storage. Address 1 is 32 bits wide with default 0x00000057. Address 2 is 20 bits wide with default 0x0F0F0. Address 3 is 8 bits wide with default 0xA5. Address 4 is 12 bits wide with default 0x800. Addresses 5 to 15 hold no register.

Top module: `tw_regport`

## Requirements
- R1: While `sle` is low, `sdi` is sampled on each rising edge of `sck`. The first four bits form the address, MSB first. The fifth bit is the direction bit, where 1 means write and 0 means read. Any bits after that are data, MSB first.
- R2: A write that carries exactly as many data bits as the register width replaces the whole register. The new value appears on `regs_q` after `sle` rises. Register `a` occupies `regs_q[a*32 +: 32]`, and the bits above its width read as zero.
- R3: A write that carries n data bits, with n smaller than the width W, loads those bits into register bits W-1 down to W-n, the first bit going to W-1. Bits W-n-1 down to 0 keep their previous values.
- R4: When a write carries more data bits than the register width, only the first W bits are used and the rest are discarded.
- R5: On a read, `sdo_en` stays low while the address and direction bits are sent. It goes high on the falling `sck` edge that follows the rising edge that sampled the direction bit. On that edge and on every later falling edge, `sdo` presents the next register bit, MSB first. After the last bit of the register width, `sdo` presents zeros.
- R6: Raising `sle` part-way through a read drops `sdo_en` and leaves the register unchanged. The next frame then works normally.
- R7: A write frame to address 0 restores every register to its default, whatever the number of data bits, including none.
- R8: A write to an address with no register changes nothing. A read from such an address returns zeros.
- R9: A write frame that ends before any data bit arrives, or any frame that ends before the direction bit, changes no register and produces no strobe.
- R10: Each write that is applied raises `wr_strobe` for exactly one clock cycle, with `wr_addr` giving the target address. Writes to address 0 are included.
- R11: While `rst_n` is low at a clock edge, all registers take their defaults and `sdo_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sle | input | 1 | Frame strobe, low for the duration of a frame |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host (input side of the shared line) |
| sdo | output | 1 | Serial read data (output side of the shared line) |
| sdo_en | output | 1 | High while the block drives the shared line |
| regs_q | output | 512 | All register contents, 32 bits per address |
| wr_strobe | output | 1 | One-cycle pulse when a write is applied |
| wr_addr | output | 4 | Address of the write being applied |

## Verification
The hardest case to reach is a read that the host abandons part-way through the data field. At that moment the output enable is high and the read shift register is half drained. A new frame must start clean from that state. The bench reads six bits of a 20-bit register, raises the strobe, checks that the line is released, and then runs a full read of a different register. It also sends more bits than the register width, and sends a write that carries no data, so that the counter saturation and the zero-count commit paths are both exercised.

// File: rtl/tw_pkg.sv
// Package: register map and shared constants for the three-wire port.
// Assumes: address 0 is the reset register and holds no storage.
package tw_pkg;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_REGS = 1 << ADDR_W;
    localparam int unsigned CNT_W    = $clog2(DATA_W + 1);
    localparam int unsigned HDR_BITS = ADDR_W + 1;
    localparam int unsigned HCNT_W   = $clog2(HDR_BITS + 1);
    localparam logic [ADDR_W-1:0] RST_ADDR = '0;

    // Width of the register at an address; 0 means no storage.
    function automatic int unsigned reg_width(input int unsigned a);
        case (a)
            1:       return 32;
            2:       return 20;
            3:       return 8;
            4:       return 12;
            default: return 0;
        endcase
    endfunction

    // Reset value of the register at an address.
    function automatic logic [DATA_W-1:0] reg_default(input int unsigned a);
        case (a)
            1:       return 32'h0000_0057;
            2:       return 32'h0000_F0F0 | 32'h0000_0000;
            3:       return 32'h0000_00A5;
            4:       return 32'h0000_0800;
            default: return '0;
        endcase
    endfunction

    // Flattened image of all defaults.
    function automatic logic [NUM_REGS*DATA_W-1:0] default_image();
        logic [NUM_REGS*DATA_W-1:0] img;
        img = '0;
        for (int unsigned i = 0; i < NUM_REGS; i++)
            img[i*DATA_W +: DATA_W] = reg_default(i);
        return img;
    endfunction
endpackage

// File: rtl/tw_sync.sv
// Module: multi-stage synchronizer for the asynchronous serial inputs.
// Assumes: inputs change slowly relative to clk; STAGES >= 1.
module tw_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop stage captures the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // Later stages settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tw_frame.sv
// Module: frame engine. Decodes the header, collects write bits, shifts out
// read bits and turns completed writes into single-cycle commit requests.
// Assumes: synchronized inputs; rd_word is left-aligned read data for addr_o.
module tw_frame
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sle_s,
    input  logic              sck_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] addr_o,
    output logic              sdo,
    output logic              sdo_en,
    output logic              wr_en,
    output logic              rst_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [CNT_W-1:0]  wr_cnt,
    output logic [DATA_W-1:0] wr_data
);
    logic              sck_p, sle_p;
    logic              sck_r, sck_f, sle_r;
    logic [HCNT_W-1:0] hcnt;
    logic [CNT_W-1:0]  dcnt;
    logic [CNT_W-1:0]  cur_width;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic              hdr_done;
    logic [DATA_W-1:0] dsr;
    logic [DATA_W-1:0] rd_sr;

    assign sck_r     = sck_s & ~sck_p & ~sle_s;
    assign sck_f     = ~sck_s & sck_p & ~sle_s;
    assign sle_r     = sle_s & ~sle_p;
    assign hdr_done  = (hcnt == HCNT_W'(HDR_BITS));
    assign cur_width = CNT_W'(reg_width(int'(addr_q)));
    assign addr_o    = addr_q;

    // Edge history for the synchronized clock and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= 1'b0;
            sle_p <= 1'b1;
        end else begin
            sck_p <= sck_s;
            sle_p <= sle_s;
        end
    end

    // Header and write-data capture on rising serial clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt   <= '0;
            dcnt   <= '0;
            addr_q <= '0;
            rw_q   <= 1'b0;
            dsr    <= '0;
        end else if (sle_s) begin
            hcnt <= '0;
            dcnt <= '0;
        end else if (sck_r) begin
            if (hcnt < HCNT_W'(ADDR_W)) begin
                addr_q <= {addr_q[ADDR_W-2:0], sdi_s};
                hcnt   <= hcnt + 1'b1;
            end else if (!hdr_done) begin
                rw_q <= sdi_s;
                hcnt <= hcnt + 1'b1;
                dsr  <= '0;
            end else if (rw_q && dcnt < cur_width) begin
                dsr  <= {dsr[DATA_W-2:0], sdi_s};
                dcnt <= dcnt + 1'b1;
            end
        end
    end

    // Read path: snapshot at the direction bit, drive on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sr  <= '0;
            sdo    <= 1'b0;
            sdo_en <= 1'b0;
        end else if (sle_s) begin
            sdo    <= 1'b0;
            sdo_en <= 1'b0;
        end else if (sck_r && hcnt == HCNT_W'(ADDR_W)) begin
            rd_sr <= rd_word;
        end else if (sck_f && hdr_done && !rw_q) begin
            sdo_en <= 1'b1;
            sdo    <= rd_sr[DATA_W-1];
            rd_sr  <= {rd_sr[DATA_W-2:0], 1'b0};
        end
    end

    // Commit request when the strobe closes a write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            rst_req <= 1'b0;
            wr_addr <= '0;
            wr_cnt  <= '0;
            wr_data <= '0;
        end else begin
            wr_en   <= 1'b0;
            rst_req <= 1'b0;
            if (sle_r && hdr_done && rw_q) begin
                wr_addr <= addr_q;
                wr_cnt  <= dcnt;
                wr_data <= dsr;
                if (addr_q == RST_ADDR)
                    rst_req <= 1'b1;
                else if (cur_width != '0 && dcnt != '0)
                    wr_en <= 1'b1;
            end
        end
    end

    // The line is released in the cycle after the strobe is seen high.
    assert_line_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sle_s |=> !sdo_en);

    // Driving begins only once a read header has been fully received.
    assert_drive_after_header_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_en) |-> $past(hdr_done && !rw_q));

    // The data bit counter never passes the addressed register width.
    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= cur_width);

    // Commit requests last a single cycle.
    assert_commit_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rst_req) |=> !(wr_en || rst_req));
endmodule

// File: rtl/tw_bank.sv
// Module: register bank. Merges left-aligned partial writes, applies the
// reset-register request and serves left-aligned read words.
// Assumes: wr_cnt is between 1 and the target width whenever wr_en is high.
module tw_bank
    import tw_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rst_req,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [CNT_W-1:0]           wr_cnt,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_word,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
    localparam logic [NUM_REGS*DATA_W-1:0] DEFAULTS = default_image();

    for (genvar a = 0; a < NUM_REGS; a++) begin : g_reg
        localparam int unsigned W = reg_width(a);
        if (W == 0) begin : g_none
            assign regs_flat[a*DATA_W +: DATA_W] = '0;
        end else begin : g_store
            logic [DATA_W-1:0] q;
            logic [2*DATA_W-1:0] ones, tmask, tdata;

            // Mask and data for the top wr_cnt bits of a W-bit register.
            always_comb begin
                ones  = ((2*DATA_W)'(1) << wr_cnt) - (2*DATA_W)'(1);
                tmask = ones << (W - int'(wr_cnt));
                tdata = {{DATA_W{1'b0}}, wr_data} << (W - int'(wr_cnt));
            end

            // Storage with reset, reset-register restore and partial merge.
            always_ff @(posedge clk) begin
                if (!rst_n || rst_req)
                    q <= reg_default(a);
                else if (wr_en && wr_addr == ADDR_W'(a))
                    q <= DATA_W'(({{DATA_W{1'b0}}, q} & ~tmask) | (tdata & tmask));
            end

            assign regs_flat[a*DATA_W +: DATA_W] = q;
        end
    end

    // Left-align the addressed register for MSB-first shifting.
    always_comb begin
        rd_word = regs_flat[int'(rd_addr)*DATA_W +: DATA_W]
                  << (DATA_W - reg_width(int'(rd_addr)));
    end

    // A reset-register write restores the full default image.
    assert_restore_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (regs_flat == DEFAULTS));

    // Writes aimed at unmapped addresses leave the bank untouched.
    assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_width(int'(wr_addr)) == 0) |=> $stable(regs_flat));
endmodule

// File: rtl/tw_regport.sv
// Module: top of the three-wire variable-length register port.
// Assumes: sck half period spans several clk cycles beyond SYNC_STAGES + 2.
module tw_regport
    import tw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sle,
    input  logic                       sck,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_en,
    output logic [NUM_REGS*DATA_W-1:0] regs_q,
    output logic                       wr_strobe,
    output logic [ADDR_W-1:0]          wr_addr
);
    logic [2:0]        pins_s;
    logic              wr_en, rst_req;
    logic [CNT_W-1:0]  wr_cnt;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_word;

    tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sle, sck, sdi}),
        .q     (pins_s)
    );

    tw_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sle_s   (pins_s[2]),
        .sck_s   (pins_s[1]),
        .sdi_s   (pins_s[0]),
        .rd_word (rd_word),
        .addr_o  (rd_addr),
        .sdo     (sdo),
        .sdo_en  (sdo_en),
        .wr_en   (wr_en),
        .rst_req (rst_req),
        .wr_addr (wr_addr),
        .wr_cnt  (wr_cnt),
        .wr_data (wr_data)
    );

    tw_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rst_req   (rst_req),
        .wr_addr   (wr_addr),
        .wr_cnt    (wr_cnt),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .regs_flat (regs_q)
    );

    assign wr_strobe = wr_en | rst_req;
endmodule

// File: tb/tw_regport_bench.sv
// Directed bench for the three-wire register port.
module tw_regport_bench;
    localparam int H = 8;  // clk cycles per sck half period

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sle = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic         sdo, sdo_en, wr_strobe;
    logic [511:0] regs_q;
    logic [3:0]   wr_addr;

    int checks = 0, fails = 0, strobes = 0;
    logic [3:0] last_addr = '0;
    logic done = 1'b0;
    logic [31:0] model [16];
    int          widths [16];

    tw_regport u_tw_regport (.clk(clk), .rst_n(rst_n), .sle(sle), .sck(sck), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .regs_q(regs_q), .wr_strobe(wr_strobe), .wr_addr(wr_addr));

    always #10 clk = ~clk;

    always @(negedge clk) if (wr_strobe) begin strobes++; last_addr = wr_addr; end

    task automatic wait_clks(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_defaults();
        for (int i = 0; i < 16; i++) begin model[i] = '0; widths[i] = 0; end
        widths[1] = 32; model[1] = 32'h57;
        widths[2] = 20; model[2] = 32'h0F0F0;
        widths[3] = 8;  model[3] = 32'hA5;
        widths[4] = 12; model[4] = 32'h800;
    endtask

    task automatic chk_bank(input string req);
        for (int i = 0; i < 16; i++)
            chk(req, 64'(regs_q[i*32 +: 32]), 64'(model[i]));
    endtask

    task automatic sbit(input logic b);
        sdi = b; wait_clks(H); sck = 1'b1; wait_clks(H); sck = 1'b0;
    endtask

    // Sends header then data (write) or collects nbits (read); sle left low.
    task automatic frame_open(input logic [3:0] a, input logic w, input int nbits,
                              input logic [63:0] wdata, output logic [63:0] rdata);
        rdata = '0;
        sle = 1'b0; wait_clks(H);
        for (int i = 3; i >= 0; i--) sbit(a[i]);
        sdi = w; wait_clks(H); sck = 1'b1; wait_clks(H);
        if (!w) chk("R5 enable low before turnaround", 64'(sdo_en), 64'd0);
        sck = 1'b0;
        if (w) begin
            for (int i = nbits - 1; i >= 0; i--) sbit(wdata[i]);
        end else begin
            for (int i = 0; i < nbits; i++) begin
                if (i > 0) begin wait_clks(H); sck = 1'b1; wait_clks(H); sck = 1'b0; end
                wait_clks(H);
                if (i == 0) chk("R5 enable after turnaround", 64'(sdo_en), 64'd1);
                rdata = {rdata[62:0], sdo};
            end
        end
    endtask

    task automatic frame_close(); wait_clks(H); sle = 1'b1; wait_clks(2 * H); endtask

    task automatic do_write(input logic [3:0] a, input int n, input logic [63:0] d);
        logic [63:0] unused;
        frame_open(a, 1'b1, n, d, unused); frame_close();
    endtask

    task automatic do_read(input logic [3:0] a, input int n, output logic [63:0] r);
        frame_open(a, 1'b0, n, '0, r); frame_close();
    endtask

    task automatic t_reset();
        set_defaults();
        chk_bank("R11 defaults");
        chk("R11 enable low", 64'(sdo_en), 64'd0);
    endtask

    task automatic t_full_write();
        logic [63:0] r; int s0;
        s0 = strobes;
        do_write(4'd1, 32, 64'hDEADBEEF); model[1] = 32'hDEADBEEF;
        chk("R2 full write", 64'(regs_q[32 +: 32]), 64'hDEADBEEF);
        chk("R10 one strobe", 64'(strobes - s0), 64'd1);
        chk("R10 strobe address", 64'(last_addr), 64'd1);
        do_read(4'd1, 32, r);
        chk("R1 R5 full read", r, 64'hDEADBEEF);
    endtask

    task automatic t_partial_write();
        do_write(4'd2, 4, 64'hA); model[2] = 32'hAF0F0;
        chk("R3 partial write", 64'(regs_q[64 +: 32]), 64'hAF0F0);
        do_write(4'd4, 1, 64'h0); model[4] = 32'h000;
        chk("R3 single-bit write", 64'(regs_q[128 +: 32]), 64'h0);
    endtask

    task automatic t_overlong();
        do_write(4'd3, 12, 64'h3C5); model[3] = 32'h3C;
        chk("R4 overlong write", 64'(regs_q[96 +: 32]), 64'h3C);
    endtask

    task automatic t_reads();
        logic [63:0] r;
        do_write(4'd4, 12, 64'hB7D); model[4] = 32'hB7D;
        do_read(4'd4, 16, r);
        chk("R5 zeros past width", r, 64'hB7D0);
        frame_open(4'd2, 1'b0, 6, '0, r);
        chk("R6 aborted read bits", r, 64'(model[2] >> 14));
        wait_clks(H); sle = 1'b1; wait_clks(2 * H);
        chk("R6 line released", 64'(sdo_en), 64'd0);
        chk("R6 register unchanged", 64'(regs_q[64 +: 32]), 64'(model[2]));
        do_read(4'd3, 8, r);
        chk("R6 next frame read", r, 64'(model[3]));
    endtask

    task automatic t_no_data();
        logic [63:0] unused; int s0;
        s0 = strobes;
        do_write(4'd3, 0, '0);
        chk_bank("R9 zero-bit write");
        sle = 1'b0; wait_clks(H); sbit(1'b0); sbit(1'b0); sbit(1'b1); frame_close();
        chk_bank("R9 short frame");
        chk("R9 no strobe", 64'(strobes - s0), 64'd0);
        unused = '0;
    endtask

    task automatic t_unmapped();
        logic [63:0] r; int s0;
        s0 = strobes;
        do_write(4'd9, 8, 64'hFF);
        chk_bank("R8 unmapped write");
        chk("R8 no strobe", 64'(strobes - s0), 64'd0);
        do_read(4'd9, 8, r);
        chk("R8 unmapped read", r, 64'd0);
    endtask

    task automatic t_reset_reg();
        int s0;
        s0 = strobes;
        do_write(4'd0, 3, 64'h2);
        set_defaults();
        chk_bank("R7 reset register");
        chk("R10 reset strobe", 64'(strobes - s0), 64'd1);
        chk("R10 reset strobe address", 64'(last_addr), 64'd0);
        do_write(4'd3, 8, 64'h11); model[3] = 32'h11;
        chk("R2 byte write", 64'(regs_q[96 +: 32]), 64'h11);
        do_write(4'd0, 0, '0);
        set_defaults();
        chk_bank("R7 zero-length reset");
    endtask

    initial begin
        wait_clks(5); rst_n = 1'b1; wait_clks(5);
        t_reset();
        t_full_write();
        t_partial_write();
        t_overlong();
        t_reads();
        t_no_data();
        t_unmapped();
        t_reset_reg();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule